// File: doc/BRIEF.md
# Virtual Lane Map Capture Sequencer

This block fills in the lane map for a multi-lane Ethernet receive path. Before the map can be read, the receive PCS must report that every lane is aligned. After that, the sequencer walks the local virtual lanes. For each lane it issues one status read on a plain request/acknowledge register port. Each returned word carries two fields: the number of the remote virtual lane that arrives on that local lane, and the number of the local physical lane that carries it.

The sequencer stores the physical lane number in a table slot chosen by the remote lane number. Slots are not chosen by the order of the reads. The finished table therefore tells timing logic further down the path which physical lane carries each of the link partner's lanes. A done flag marks the table as complete. An error flag reports any status word whose remote lane number points outside the table.

If alignment is lost at any point, the sequence stops and the done flag drops. A complete new capture starts from the first lane once alignment comes back.

Top module: `vl_map_capture`

## Requirements
- R1: While reset is held and just after it is released, `rd_req`, `done` and `idx_err` are 0 and every table entry in `map_flat` is 0.
- R2: `rd_req` stays 0 in any cycle that follows a cycle in which `pcs_aligned` was 0.
- R3: Once alignment is seen, reads are issued in strict ascending local lane order 0 to 19, with one outstanding request at a time. `rd_req` stays high and `rd_addr` stays stable until `rd_ack` is sampled high.
- R4: The remote lane field is `rd_data[4:0]` and the physical lane field is `rd_data[10:8]`; all other data bits are ignored. After an accepted response with remote index r < 20, entry r (`map_flat[3*r+2:3*r]`) holds that physical lane number.
- R5: When two lanes report the same remote index, the entry holds the physical lane from the later read, since reads are made in ascending local lane order.
- R6: A remote index of 20 to 31 writes no entry, and `idx_err` is 1 from the cycle after that response until the next capture starts.
- R7: `done` rises in the cycle after the 20th response is accepted, and exactly 20 responses are accepted per capture.
- R8: When `pcs_aligned` drops, `rd_req` and `done` are 0 from the next cycle on. When alignment returns, a new capture starts at lane 0. At the start of that capture all entries and `idx_err` are cleared, so entries not written by the new capture read as 0.
- R9: A read of local lane 12 that returns remote lane 5 and physical lane 2 leaves entry 5 holding 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcs_aligned | input | 1 | Receive PCS reports that all lanes are aligned |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_addr | output | 5 | Local virtual lane index being read |
| rd_ack | input | 1 | Read response valid; `rd_data` is taken in this cycle |
| rd_data | input | 32 | Status word of the requested lane |
| map_flat | output | 60 | Remote-lane table, 3 bits per remote lane index |
| done | output | 1 | Table complete and valid |
| idx_err | output | 1 | A response held an out-of-range remote lane index |

## Verification
The assertions assume that the read port answers only a pending request, with one `rd_ack` pulse per request. They also assume that `rd_ack` counts only while `pcs_aligned` is high. The bench responder follows these rules: it acknowledges only while `rd_req` is high, after a random delay of zero to two cycles. It then lowers `rd_ack` on the next cycle and drops any pending answer once the request goes away. Alignment changes come from directed steps, including one drop in the middle of a capture. The random content of the status words covers duplicate and out-of-range remote indices. The bits outside the two fields are filled with random values.

// File: rtl/vlm_pkg.sv
`timescale 1ns/1ps
package vlm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_DONE = 2'd2
    } vlm_state_e;

endpackage

// File: rtl/vlm_field_extract.sv
`timescale 1ns/1ps
module vlm_field_extract #(
    parameter int DATA_W    = 32,
    parameter int VL_W      = 5,
    parameter int PL_W      = 3,
    parameter int REM_LSB   = 0,
    parameter int PHY_LSB   = 8,
    parameter int NUM_LANES = 20
) (
    input  logic [DATA_W-1:0] rd_data,
    output logic [VL_W-1:0]   rem_idx,
    output logic [PL_W-1:0]   phy_idx,
    output logic              rem_ok
);
    localparam logic [VL_W-1:0] LIMIT = VL_W'(NUM_LANES);

    logic [DATA_W-1:0] rem_shift;
    logic [DATA_W-1:0] phy_shift;

    always_comb begin
        rem_shift = rd_data >> REM_LSB;
        phy_shift = rd_data >> PHY_LSB;
        rem_idx   = rem_shift[VL_W-1:0];
        phy_idx   = phy_shift[PL_W-1:0];
        rem_ok    = (rem_idx < LIMIT);
    end

endmodule

// File: rtl/vlm_seq_ctrl.sv
`timescale 1ns/1ps
module vlm_seq_ctrl
    import vlm_pkg::*;
#(
    parameter int NUM_LANES = 20,
    parameter int ADDR_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aligned,
    input  logic              rd_ack,
    input  logic              rem_ok,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              tbl_clr,
    output logic              tbl_we,
    output logic              done,
    output logic              err
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_LANES - 1);

    typedef struct packed {
        vlm_state_e        state;
        logic [ADDR_W-1:0] lane;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic start_d;
    logic accept_d;

    always_comb begin
        ctl_d    = ctl_q;
        start_d  = 1'b0;
        accept_d = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (aligned) begin
                    ctl_d.state = ST_READ;
                    ctl_d.lane  = '0;
                    ctl_d.err   = 1'b0;
                    start_d     = 1'b1;
                end
            end
            ST_READ: begin
                if (!aligned) begin
                    ctl_d.state = ST_IDLE;
                end else if (rd_ack) begin
                    accept_d = 1'b1;
                    if (!rem_ok) begin
                        ctl_d.err = 1'b1;
                    end
                    if (ctl_q.lane == LAST) begin
                        ctl_d.state = ST_DONE;
                    end else begin
                        ctl_d.lane = ctl_q.lane + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                if (!aligned) begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.lane  <= '0;
            ctl_q.err   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_req  = (ctl_q.state == ST_READ);
    assign rd_addr = ctl_q.lane;
    assign done    = (ctl_q.state == ST_DONE);
    assign err     = ctl_q.err;
    assign tbl_clr = start_d;
    assign tbl_we  = accept_d && rem_ok;

    // R2
    no_req_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |=> !rd_req);

    // R3
    first_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> (rd_addr == '0));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && aligned) |=> (rd_req && $stable(rd_addr)));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && aligned && (rd_addr != LAST)) |=>
        (rd_req && (rd_addr == ADDR_W'($past(rd_addr) + 1'b1))));

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rd_req && rd_ack && aligned && (rd_addr == LAST)));

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |=> (!done && !rd_req));

    // R6
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && aligned && !rem_ok) |=> err);

endmodule

// File: rtl/vlm_map_table.sv
`timescale 1ns/1ps
module vlm_map_table #(
    parameter int NUM_LANES = 20,
    parameter int VL_W      = 5,
    parameter int PL_W      = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      we,
    input  logic [VL_W-1:0]           waddr,
    input  logic [PL_W-1:0]           wdata,
    output logic [NUM_LANES*PL_W-1:0] map_flat
);
    localparam logic [VL_W-1:0] LIMIT = VL_W'(NUM_LANES);

    logic [PL_W-1:0] ent_d [NUM_LANES];
    logic [PL_W-1:0] ent_q [NUM_LANES];

    always_comb begin
        for (int i = 0; i < NUM_LANES; i++) begin
            ent_d[i] = ent_q[i];
            if (clr) begin
                ent_d[i] = '0;
            end else if (we && (waddr == VL_W'(i))) begin
                ent_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LANES; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            ent_q <= ent_d;
        end
    end

    // R6
    write_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (waddr < LIMIT));

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_ent
        assign map_flat[g*PL_W +: PL_W] = ent_q[g];

        // R4
        map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !clr && (waddr == VL_W'(g))) |=> (ent_q[g] == $past(wdata)));

        // R8
        map_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (ent_q[g] == '0));
    end

endmodule

// File: rtl/vl_map_capture.sv
`timescale 1ns/1ps
module vl_map_capture #(
    parameter int NUM_LANES = 20,
    parameter int VL_W      = 5,
    parameter int PL_W      = 3,
    parameter int DATA_W    = 32,
    parameter int REM_LSB   = 0,
    parameter int PHY_LSB   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pcs_aligned,
    output logic                      rd_req,
    output logic [$clog2(NUM_LANES)-1:0] rd_addr,
    input  logic                      rd_ack,
    input  logic [DATA_W-1:0]         rd_data,
    output logic [NUM_LANES*PL_W-1:0] map_flat,
    output logic                      done,
    output logic                      idx_err
);
    localparam int ADDR_W = $clog2(NUM_LANES);

    logic [VL_W-1:0] rem_idx;
    logic [PL_W-1:0] phy_idx;
    logic            rem_ok;
    logic            tbl_clr;
    logic            tbl_we;

    vlm_field_extract #(
        .DATA_W   (DATA_W),
        .VL_W     (VL_W),
        .PL_W     (PL_W),
        .REM_LSB  (REM_LSB),
        .PHY_LSB  (PHY_LSB),
        .NUM_LANES(NUM_LANES)
    ) u_extract (
        .rd_data (rd_data),
        .rem_idx (rem_idx),
        .phy_idx (phy_idx),
        .rem_ok  (rem_ok)
    );

    vlm_seq_ctrl #(
        .NUM_LANES(NUM_LANES),
        .ADDR_W   (ADDR_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .aligned (pcs_aligned),
        .rd_ack  (rd_ack),
        .rem_ok  (rem_ok),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .tbl_clr (tbl_clr),
        .tbl_we  (tbl_we),
        .done    (done),
        .err     (idx_err)
    );

    vlm_map_table #(
        .NUM_LANES(NUM_LANES),
        .VL_W     (VL_W),
        .PL_W     (PL_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tbl_clr),
        .we       (tbl_we),
        .waddr    (rem_idx),
        .wdata    (phy_idx),
        .map_flat (map_flat)
    );

endmodule

// File: tb/tb_vl_map_capture.sv
`timescale 1ns/1ps
module tb_vl_map_capture;
    localparam int NL  = 20;
    localparam int PLW = 3;
    localparam int DW  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pcs_aligned = 1'b0;
    logic              rd_ack = 1'b0;
    logic [DW-1:0]     rd_data = '0;
    logic              rd_req;
    logic [4:0]        rd_addr;
    logic [NL*PLW-1:0] map_flat;
    logic              done;
    logic              idx_err;

    always #2.5 clk = ~clk;

    vl_map_capture dut (
        .clk(clk), .rst_n(rst_n), .pcs_aligned(pcs_aligned),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .map_flat(map_flat), .done(done), .idx_err(idx_err)
    );

    int n_chk = 0, n_fail = 0;
    int resp_rem [NL];
    int resp_phy [NL];
    int exp_map  [NL];
    bit exp_err;
    int cyc = 0, acc_count = 0, last_acc = -1, done_rise = -1, req_cycles = 0;
    int acc_addr [64];
    bit done_prev = 1'b0;
    int lat = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int map_at(input int i);
        return int'(map_flat[i*PLW +: PLW]);
    endfunction

    // monitor: inputs change just after posedge, so negedge values are what the next edge sees
    always @(negedge clk) begin
        cyc++;
        if (rd_req) req_cycles++;
        if (rd_req && rd_ack && pcs_aligned) begin
            if (acc_count < 64) acc_addr[acc_count] = int'(rd_addr);
            acc_count++;
            last_acc = cyc;
        end
        if (done && !done_prev) done_rise = cyc;
        done_prev = done;
    end

    // register-port model: one pulse per pending request, 0..2 cycles of latency
    always @(posedge clk) begin
        #1;
        if (rd_ack) begin
            rd_ack = 1'b0;
        end else if (rd_req) begin
            if (lat == 0) begin
                rd_data       = $urandom;
                rd_data[4:0]  = 5'(resp_rem[rd_addr]);
                rd_data[10:8] = 3'(resp_phy[rd_addr]);
                rd_ack        = 1'b1;
                lat           = int'($urandom % 3);
            end else begin
                lat--;
            end
        end else begin
            lat = 0;
        end
    end

    task automatic set_aligned(input bit v);
        @(posedge clk);
        #1 pcs_aligned = v;
    endtask

    function automatic void compute_expected();
        for (int i = 0; i < NL; i++) exp_map[i] = 0;
        exp_err = 1'b0;
        for (int l = 0; l < NL; l++) begin
            if (resp_rem[l] < NL) exp_map[resp_rem[l]] = resp_phy[l];
            else exp_err = 1'b1;
        end
    endfunction

    task automatic fill_perm();
        for (int i = 0; i < NL; i++) begin
            resp_rem[i] = i;
            resp_phy[i] = int'($urandom % 8);
        end
        for (int i = NL - 1; i > 0; i--) begin
            int j = int'($urandom % (i + 1));
            int t = resp_rem[i];
            resp_rem[i] = resp_rem[j];
            resp_rem[j] = t;
        end
    endtask

    task automatic capture();
        bit order_ok;
        int bad_i;
        compute_expected();
        acc_count = 0; last_acc = -1; done_rise = -1;
        set_aligned(1'b1);
        for (int c = 0; c < 3000 && !done; c++) @(negedge clk);
        @(negedge clk);
        check(done == 1'b1, "R7", "done after capture", int'(done), 1);
        check(acc_count == NL, "R7", "responses accepted", acc_count, NL);
        check(done_rise == last_acc + 1, "R7", "done rise cycle", done_rise, last_acc + 1);
        order_ok = 1'b1; bad_i = 0;
        for (int i = 0; i < NL && i < acc_count; i++) begin
            if (order_ok && acc_addr[i] != i) begin
                order_ok = 1'b0; bad_i = i;
            end
        end
        check(order_ok, "R3", "read order", order_ok ? 0 : acc_addr[bad_i], bad_i);
        for (int r = 0; r < NL; r++) begin
            check(map_at(r) == exp_map[r], "R4", $sformatf("entry %0d", r), map_at(r), exp_map[r]);
        end
        check(idx_err == exp_err, "R6", "idx_err", int'(idx_err), int'(exp_err));
    endtask

    task automatic release_link();
        set_aligned(1'b0);
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R8", "done after alignment loss", int'(done), 0);
        check(rd_req == 1'b0, "R8", "rd_req after alignment loss", int'(rd_req), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h1badf00d));
        for (int i = 0; i < NL; i++) begin
            resp_rem[i] = i; resp_phy[i] = 0;
        end
        repeat (4) @(negedge clk);
        check(rd_req == 1'b0 && done == 1'b0 && idx_err == 1'b0, "R1", "outputs in reset",
              int'({rd_req, done, idx_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_req == 1'b0, "R1", "rd_req after reset", int'(rd_req), 0);
        check(done == 1'b0 && idx_err == 1'b0, "R1", "flags after reset", int'({done, idx_err}), 0);
        check(map_flat == '0, "R1", "table after reset", int'(map_flat != '0), 0);

        // R2: no reads while the PCS is not aligned
        repeat (30) @(negedge clk);
        check(req_cycles == 0, "R2", "requests while unaligned", req_cycles, 0);

        // R9: lane 12 reports remote 5 on physical 2
        fill_perm();
        for (int j = 0; j < NL; j++) begin
            if (resp_rem[j] == 5) begin
                resp_rem[j] = resp_rem[12];
                resp_rem[12] = 5;
            end
        end
        resp_phy[12] = 2;
        capture();
        check(map_at(5) == 2, "R9", "entry 5 from lane 12", map_at(5), 2);
        release_link();

        // R5: two lanes with the same remote index, later one wins
        fill_perm();
        resp_rem[3] = 9; resp_phy[3] = 1;
        resp_rem[7] = 9; resp_phy[7] = 6;
        capture();
        check(map_at(9) == 6, "R5", "duplicate remote index, later lane", map_at(9), 6);
        release_link();

        // random contents, duplicates allowed
        for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < NL; i++) begin
                resp_rem[i] = int'($urandom % NL);
                resp_phy[i] = int'($urandom % 8);
            end
            capture();
            release_link();
        end

        // R6: out-of-range remote indices, boundary values 19, 20 and 31
        fill_perm();
        resp_rem[0] = 20; resp_rem[4] = 25; resp_rem[10] = 31; resp_rem[1] = 19;
        capture();
        release_link();
        check(idx_err == 1'b1, "R6", "idx_err held until restart", int'(idx_err), 1);

        // R8: abort mid-capture, restart from lane 0 with cleared table and error
        fill_perm();
        acc_count = 0;
        set_aligned(1'b1);
        for (int c = 0; c < 3000 && acc_count < 8; c++) @(negedge clk);
        set_aligned(1'b0);
        repeat (2) @(negedge clk);
        check(rd_req == 1'b0, "R8", "rd_req after mid-capture abort", int'(rd_req), 0);
        check(done == 1'b0, "R8", "done after mid-capture abort", int'(done), 0);
        repeat (10) @(negedge clk);
        fill_perm();
        capture();
        release_link();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R7 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule